// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind a two-wire bus front end and turns the data bytes of one write transaction into a single page update of a small byte array. The front end sends it one-cycle event strobes: transaction start, word address loaded, data byte received, acknowledge finished, and stop. The block keeps an address pointer and a page-wide staging buffer with a per-slot loaded mask. It tells the front end, through `ackGrant`, whether the next data byte may be acknowledged.

A stop that ends a well-formed transaction starts a timed write cycle. `busy` stays high for the whole cycle and every bus event is ignored. When the cycle ends, only the loaded slots are copied into the array. A malformed ending drops the staged bytes and leaves the array as it was. So does a new start before the stop. A combinational read port shows the array contents.

Top module: `page_commit_ctrl`

## Requirements
- R1: A granted data byte is stored at the pointer's slot. Then only the low PAGE_W bits of the pointer (default 6 bits, 64-byte page) advance, wrapping from 63 to 0, while the page bits stay the same. For example, twelve bytes starting at in-page offset 60 land at offsets 60..63 and then 0..7.
- R2: After such a wrap the pointer holds the next offset. A thirteenth byte in the same transaction after the example in R1 lands at offset 8.
- R3: When more bytes arrive than a page holds, a later byte replaces the earlier staged byte at the same offset. The array receives the last value sent for each offset.
- R4: A stop commits only if the last granted data byte was followed by its acknowledge-complete strobe. At the commit, only the offsets loaded in this transaction change. Every other array byte keeps its value.
- R5: A stop that comes before any acknowledged byte, or between a granted byte and its acknowledge, starts no write cycle (`busy` stays 0) and leaves the array unchanged.
- R6: After a committing stop, `busy` rises on the next clock edge and stays high for exactly WRITE_CYCLES clock cycles. The array keeps its old contents while `busy` is high and shows the new bytes once `busy` falls.
- R7: While `busy` is high, `ackGrant` is 0, and start, stop, address, byte and acknowledge strobes have no effect on the array or on the cycle length.
- R8: A word address A is protected when protBase <= A <= protLimit (unsigned, inclusive). If the pointer holds a protected address, `ackGrant` is 0. A byte strobed anyway is not stored and the pointer does not move.
- R9: A start event before the stop discards all staged bytes without writing.
- R10: After reset, `busy` and `ackGrant` are 0 and every array byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startEv | input | 1 | Bus start condition seen (one-cycle strobe) |
| stopEv | input | 1 | Bus stop condition seen (one-cycle strobe) |
| addrLoad | input | 1 | Word address byte received; load `addrIn` |
| addrIn | input | ADDR_W | Word address for the transaction |
| byteDone | input | 1 | Data byte received on the bus |
| byteIn | input | 8 | Data byte value |
| ackDone | input | 1 | Acknowledge bit for the last data byte finished |
| protBase | input | ADDR_W | Lowest protected word address |
| protLimit | input | ADDR_W | Highest protected word address |
| rdAddr | input | ADDR_W | Array read address |
| rdData | output | 8 | Array byte at `rdAddr` |
| busy | output | 1 | Write cycle in progress |
| ackGrant | output | 1 | Next data byte may be acknowledged |

## Verification
The main function is tried with short runs inside a page, with a run crossing the page end from offset 60, and with a run longer than a page. These separate the correct wrap from a carry into the page bits, and last-value-wins from first-value-wins. Endings are varied between a clean stop, a stop before the final acknowledge, a stop straight after the address and a restart. This tells a commit apart from a silent abort. Random transactions with random protected windows check that grant, storage and pointer movement agree byte by byte against a bench model of the array. The bench also strobes every input during a write cycle to show that none of them is seen.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [2:0] {
    PGW_IDLE,
    PGW_ADDR,
    PGW_MID,
    PGW_ACKED,
    PGW_WRITE
  } pgwState_t;

  typedef struct packed {
    logic loadAddr;
    logic storeByte;
    logic clearMask;
    logic commit;
  } pgwStrobe_t;

endpackage

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
#(
  parameter int WRITE_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic       addrLoad,
  input  logic       byteDone,
  input  logic       ackDone,
  input  logic       inProt,
  output pgwStrobe_t strobe,
  output logic       busy,
  output logic       ackGrant
);
  localparam int TW = $clog2(WRITE_CYCLES + 1);

  pgwState_t state, nextState;
  logic [TW-1:0] timer;
  logic canTake;

  assign busy     = (state == PGW_WRITE);
  assign canTake  = (state == PGW_ADDR) || (state == PGW_ACKED);
  assign ackGrant = canTake && !inProt;

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      PGW_WRITE: begin
        if (timer == '0) begin
          strobe.commit = 1'b1;
          nextState     = PGW_IDLE;
        end
      end
      default: begin
        if (startEv) begin
          strobe.clearMask = 1'b1;
          nextState        = PGW_IDLE;
        end else if (stopEv) begin
          if (state == PGW_ACKED) begin
            nextState = PGW_WRITE;
          end else begin
            strobe.clearMask = 1'b1;
            nextState        = PGW_IDLE;
          end
        end else if (addrLoad && state == PGW_IDLE) begin
          strobe.loadAddr  = 1'b1;
          strobe.clearMask = 1'b1;
          nextState        = PGW_ADDR;
        end else if (byteDone && ackGrant) begin
          strobe.storeByte = 1'b1;
          nextState        = PGW_MID;
        end else if (ackDone && state == PGW_MID) begin
          nextState = PGW_ACKED;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= PGW_IDLE;
      timer <= '0;
    end else begin
      state <= nextState;
      if (state != PGW_WRITE && nextState == PGW_WRITE) begin
        timer <= TW'(WRITE_CYCLES - 1);
      end else if (busy && timer != '0) begin
        timer <= timer - 1'b1;
      end
    end
  end

  // R6: the write cycle is entered only through a stop event
  assert_busy_from_stop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !$past(busy)) |-> $past(stopEv));

  // R5: a stop between a byte and its acknowledge never starts a write
  assert_abort_no_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stopEv && state == PGW_MID) |=> !busy);

  // R7: no staging activity while the write cycle runs
  assert_busy_no_store_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!strobe.storeByte && !strobe.loadAddr && !ackGrant));

endmodule

// File: rtl/pgw_datapath.sv
module pgw_datapath
  import pgw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  pgwStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        byteIn,
  input  logic [ADDR_W-1:0] protBase,
  input  logic [ADDR_W-1:0] protLimit,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              inProt,
  output logic [7:0]        rdData
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int MEM_BYTES  = 1 << ADDR_W;
  localparam int PAGE_BITS  = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0]     ptr;
  logic [PAGE_W-1:0]     slot;
  logic [PAGE_BITS-1:0]  pageSel;
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;
  logic [7:0]            arr [MEM_BYTES];

  assign slot    = ptr[PAGE_W-1:0];
  assign pageSel = ptr[ADDR_W-1:PAGE_W];
  assign inProt  = (ptr >= protBase) && (ptr <= protLimit);
  assign rdData  = arr[rdAddr];

  // Pointer: page bits only change on an address load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strobe.loadAddr) begin
      ptr <= addrIn;
    end else if (strobe.storeByte) begin
      ptr[PAGE_W-1:0] <= slot + PAGE_W'(1);
    end
  end

  // Staging buffer and loaded mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mask <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
    end else if (strobe.clearMask || strobe.commit) begin
      mask <= '0;
    end else if (strobe.storeByte) begin
      pageBuf[slot] <= byteIn;
      mask[slot]    <= 1'b1;
    end
  end

  // Array: loaded slots copied at the end of the write cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) arr[i] <= '0;
    end else if (strobe.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (mask[i]) arr[{pageSel, PAGE_W'(i)}] <= pageBuf[i];
      end
    end
  end

  // R1: in-page bits advance with wrap, page bits hold
  assert_wrap_in_page_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeByte |=> ((ptr[PAGE_W-1:0] == PAGE_W'($past(ptr[PAGE_W-1:0]) + 1))
                          && $stable(ptr[ADDR_W-1:PAGE_W])));

  // R8: control never stores into a protected address
  assert_prot_no_store_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeByte |-> !inProt);

  // R4: staged bytes are consumed by the commit
  assert_commit_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> (mask == '0));

endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
  import pgw_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int PAGE_W       = 6,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              byteDone,
  input  logic [7:0]        byteIn,
  input  logic              ackDone,
  input  logic [ADDR_W-1:0] protBase,
  input  logic [ADDR_W-1:0] protLimit,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              busy,
  output logic              ackGrant
);
  pgwStrobe_t strobe;
  logic inProt;

  pgw_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) ctrl (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .addrLoad(addrLoad), .byteDone(byteDone), .ackDone(ackDone),
    .inProt(inProt), .strobe(strobe), .busy(busy), .ackGrant(ackGrant)
  );

  pgw_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addrIn(addrIn),
    .byteIn(byteIn), .protBase(protBase), .protLimit(protLimit),
    .rdAddr(rdAddr), .inProt(inProt), .rdData(rdData)
  );

endmodule

// File: tb/page_commit_ctrl_test.sv
module page_commit_ctrl_test;
  localparam int WC = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startEv = 0, stopEv = 0, addrLoad = 0, byteDone = 0, ackDone = 0;
  logic [7:0] addrIn = 0, byteIn = 0, protBase = 8'hFF, protLimit = 8'h00, rdAddr = 0;
  logic [7:0] rdData;
  logic busy, ackGrant;

  int nChecks = 0;
  int nFails = 0;
  logic [7:0] mem [256];

  always #5 clk = ~clk;

  page_commit_ctrl #(.ADDR_W(8), .PAGE_W(6), .WRITE_CYCLES(WC)) uut (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .addrLoad(addrLoad), .addrIn(addrIn), .byteDone(byteDone), .byteIn(byteIn),
    .ackDone(ackDone), .protBase(protBase), .protLimit(protLimit),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .ackGrant(ackGrant)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit isProt(input int a);
    return (a >= int'(protBase)) && (a <= int'(protLimit));
  endfunction

  function automatic int nextPtr(input int p);
    return (p & 8'hC0) | ((p + 1) & 8'h3F);
  endfunction

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  // sel: 0 start, 1 stop, 2 addrLoad, 3 byteDone, 4 ackDone
  task automatic pulse(input int sel);
    @(negedge clk);
    case (sel)
      0: startEv = 1; 1: stopEv = 1; 2: addrLoad = 1; 3: byteDone = 1; default: ackDone = 1;
    endcase
    @(negedge clk);
    startEv = 0; stopEv = 0; addrLoad = 0; byteDone = 0; ackDone = 0;
  endtask

  task automatic checkArray(input string req);
    int bad = 0;
    int firstA = -1;
    int firstV = 0;
    for (int a = 0; a < 256; a++) begin
      rdAddr = 8'(a);
      #1;
      if (rdData !== mem[a]) begin
        if (firstA < 0) begin firstA = a; firstV = rdData; end
        bad++;
      end
    end
    check(bad == 0, req, firstV, (firstA < 0) ? 0 : int'(mem[firstA]));
  endtask

  // mode: 0 clean stop, 1 stop before final ack, 2 restart instead of stop
  task automatic runTxn(input int addr, input int n, input int mode, input bit inject);
    logic [7:0] bufM [64];
    bit msk [64];
    int p = addr;
    int st = 0;
    int cnt;
    int probe = -1;
    for (int i = 0; i < 64; i++) msk[i] = 0;
    pulse(0);
    addrIn = 8'(addr);
    pulse(2);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = 8'($urandom);
      bit g = !isProt(p);
      @(negedge clk);
      check(ackGrant == g, "R8 grant", ackGrant, g);
      byteIn = d;
      byteDone = 1;
      @(negedge clk);
      byteDone = 0;
      if (g) begin
        bufM[p & 63] = d;
        msk[p & 63] = 1;
        if (probe < 0) probe = p;
        p = nextPtr(p);
        st = 1;
        if (!(mode == 1 && k == n - 1)) begin
          pulse(4);
          st = 2;
        end
      end
    end
    if (mode == 2) begin
      pulse(0);
      check(busy == 0, "R9 restart no write", busy, 0);
      checkArray("R9 array kept");
      return;
    end
    pulse(1);
    if (st != 2) begin
      check(busy == 0, "R5 abort no busy", busy, 0);
      @(negedge clk);
      check(busy == 0, "R5 abort stays idle", busy, 0);
      checkArray("R5 array kept");
      return;
    end
    cnt = 0;
    for (int t = 0; t < WC + 10; t++) begin
      if (!busy) break;
      cnt++;
      if (cnt == 3) begin
        rdAddr = 8'(probe);
        #1;
        check(rdData == mem[probe], "R6 array old while busy", rdData, mem[probe]);
      end
      if (inject && cnt == 5) begin
        check(ackGrant == 0, "R7 grant low while busy", ackGrant, 0);
        addrIn = 8'($urandom); byteIn = 8'($urandom);
        startEv = 1; stopEv = 1; addrLoad = 1; byteDone = 1; ackDone = 1;
      end else begin
        startEv = 0; stopEv = 0; addrLoad = 0; byteDone = 0; ackDone = 0;
      end
      @(negedge clk);
    end
    startEv = 0; stopEv = 0; addrLoad = 0; byteDone = 0; ackDone = 0;
    check(cnt == WC, inject ? "R7 cycle length" : "R6 busy length", cnt, WC);
    for (int i = 0; i < 64; i++)
      if (msk[i]) mem[(addr & 8'hC0) | i] = bufM[i];
    checkArray("R4 commit");
    check(ackGrant == 0, "R7 idle after cycle", ackGrant, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    void'($urandom(32'd12345));
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(busy == 0, "R10 busy", busy, 0);
    check(ackGrant == 0, "R10 grant", ackGrant, 0);
    checkArray("R10 array zero");
    rstN = 1;
    @(negedge clk);

    // R1 wrap from offset 60 on page 1, R2 thirteenth byte at offset 8
    runTxn(64 + 60, 13, 0, 0);
    checkArray("R1 R2 wrap placement");
    // R3 more than a page
    runTxn(128 + 5, 70, 0, 0);
    checkArray("R3 overwrite");
    // R5 stop before final ack, and stop with no data
    runTxn(10, 3, 1, 0);
    runTxn(20, 0, 0, 0);
    // R9 restart discards
    runTxn(200, 6, 2, 0);
    // R8 protected window inside a page
    protBase = 8'd36; protLimit = 8'd40;
    runTxn(33, 10, 0, 0);
    protBase = 8'hFF; protLimit = 8'h00;
    // R7 inputs ignored during the write cycle
    runTxn(250, 4, 0, 1);

    for (int r = 0; r < 30; r++) begin
      int m = $urandom % 4;
      if ($urandom % 3 == 0) begin
        int b = $urandom % 256;
        protBase = 8'(b);
        protLimit = 8'((b + $urandom % 40 > 255) ? 255 : b + $urandom % 40);
      end else begin
        protBase = 8'hFF; protLimit = 8'h00;
      end
      runTxn($urandom % 256, 1 + $urandom % 80, (m == 3) ? 0 : m, ($urandom % 4) == 0);
    end
    finishRun();
  end
endmodule